// File: doc/BRIEF.md
# UART Host Transport with Byte Flow Control

This block moves command and event bytes between a host processor and a radio controller over an asynchronous serial link. Bytes written on the transmit side wait in a transmit FIFO. The transmitter sends them as start bit, eight data bits (LSB first), an optional parity bit and one stop bit. Frames arriving on the receive line are oversampled sixteen times per bit and decided by a three-sample majority vote at mid-bit. The recovered bytes are placed in a receive FIFO that the controller drains.

Flow control works one byte at a time. The block raises a stop request toward the host once the receive FIFO fill goes above a programmable threshold. It drops that request only when the fill has fallen below the threshold by more than a programmable hysteresis. A stop request from the host is sampled before each new byte, and a byte already on the wire always runs to its stop bit. Receive line conditions and transmit underflow are recorded in sticky flags that are cleared by writing ones. The bit-rate divisor can be changed at run time. A new value is clamped to the legal range and waits until every queued byte has left at the old rate.

Top module: `hci_uart_xport`

## Requirements
- R1: After reset the serial output is high, the stop request to the host is low, all error flags are zero, the receive FIFO is empty and the active divisor equals DEF_DIV.
- R2: A transmitted frame is a low start bit, eight data bits LSB first, a parity bit if parity is on, and a high stop bit. Every bit lasts 16 times the active divisor in clock cycles, and the serial output is high whenever no frame is in progress.
- R3: A correctly framed byte on the receive line appears at the head of the receive FIFO with the same value.
- R4: cfg_parity selects the parity mode: 0 none, 1 even, 2 odd (3 acts as none). When parity is on, the transmitter inserts the parity bit. A received byte with wrong parity is dropped and sets flag bit 4.
- R5: A low pulse on the receive line that is high again at the start bit's midpoint is ignored: no byte, no framing error.
- R6: While the host's stop input is high, no new frame starts. If it rises during a frame, that frame completes with the correct value and the next queued byte waits until the input falls.
- R7: The stop request rises when the receive fill is greater than cfg_rts_thresh. It falls when fill plus cfg_rts_hyst is less than cfg_rts_thresh. Otherwise it holds.
- R8: A byte received while the receive FIFO is full is dropped, the stored bytes are kept, and flag bit 3 is set.
- R9: A frame whose stop bit is sampled low is dropped and sets flag bit 2.
- R10: A receive line held low for more than one full frame time sets flag bit 0.
- R11: A receive line that stays high for one full frame time after a completed frame sets flag bit 1 once.
- R12: If the transmitter finishes a byte while tx_msg_active is high and its FIFO is empty, flag bit 5 is set.
- R13: A divisor request is clamped to [MIN_DIV, DEF_DIV]. It takes effect only once the transmit FIFO is empty and no frame is in progress.
- R14: Error flags stay set until the matching bit of err_clr is pulsed high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_rx | input | 1 | Serial receive line |
| uart_tx | output | 1 | Serial transmit line |
| cts_stop | input | 1 | Host asks the block to stop sending (high = stop) |
| rts_stop | output | 1 | Block asks the host to stop sending (high = stop) |
| tx_data | input | 8 | Byte to queue for transmission |
| tx_valid | input | 1 | Queue tx_data this cycle |
| tx_ready | output | 1 | Transmit FIFO has room |
| tx_msg_active | input | 1 | A message is in progress, so an empty FIFO is an underflow |
| rx_data | output | 8 | Head of receive FIFO |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_pop | input | 1 | Remove head of receive FIFO |
| rx_level | output | LVL_W | Receive FIFO fill |
| cfg_parity | input | 2 | Parity mode |
| cfg_rts_thresh | input | LVL_W | Fill threshold for the stop request |
| cfg_rts_hyst | input | LVL_W | Release hysteresis |
| cfg_div | input | DIV_W | Requested clocks per oversample tick |
| cfg_div_load | input | 1 | Request the divisor change |
| div_active | output | DIV_W | Divisor in use |
| err_flags | output | 6 | Sticky flags: 0 break, 1 idle, 2 framing, 3 overflow, 4 parity, 5 underflow |
| err_clr | input | 6 | Write-one-to-clear for err_flags |

## Verification
The hardest situation to reach is a host stop request that arrives in the middle of a frame while a second byte is already queued. The bench runs a capture of the serial output in parallel with a branch that waits for the start edge and raises the stop input three bit times later. It then checks that the first byte decodes cleanly and that the line stays high for several frame times until the input is released. A deferred divisor change is reached by requesting it right after queueing three bytes, so the old rate must hold across all three frames. The receive FIFO is driven to full and then past full to see that the ninth byte is lost and not written over the older ones.

// File: rtl/hci_uart_pkg.sv
package hci_uart_pkg;

    localparam int BYTE_W = 8;
    localparam int OVS    = 16;
    localparam int MID    = 8;
    localparam int ERR_W  = 6;

    localparam int ERR_BREAK = 0;
    localparam int ERR_IDLE  = 1;
    localparam int ERR_FRAME = 2;
    localparam int ERR_OVFL  = 3;
    localparam int ERR_PAR   = 4;
    localparam int ERR_UNDF  = 5;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAIT_HI
    } rx_state_e;

    typedef enum logic {
        TX_IDLE,
        TX_SHIFT
    } tx_state_e;

    typedef struct packed {
        logic brk;
        logic idle;
        logic frame;
        logic par;
    } rx_evt_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic par_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

    function automatic logic par_bit(input logic [BYTE_W-1:0] d, input logic [1:0] mode);
        return (^d) ^ (mode == PAR_ODD);
    endfunction

    // oversample ticks in one whole frame
    function automatic logic [8:0] frame_ticks(input logic [1:0] mode);
        return par_on(mode) ? 9'(11 * OVS) : 9'(10 * OVS);
    endfunction

endpackage

// File: rtl/hci_byte_fifo.sv
module hci_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            cnt <= cnt + LW'(do_push) - LW'(do_pop);
        end
    end

endmodule

// File: rtl/hci_baud_ctl.sv
module hci_baud_ctl #(
    parameter int DIV_W   = 16,
    parameter int DEF_DIV = 26,
    parameter int MIN_DIV = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_req,
    input  logic             div_load,
    input  logic             drained,
    output logic             tick,
    output logic [DIV_W-1:0] div_active
);

    logic [DIV_W-1:0] div_q, pend_div_q, cnt_q;
    logic             pend_q, apply;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] r);
        if (r < DIV_W'(MIN_DIV)) return DIV_W'(MIN_DIV);
        if (r > DIV_W'(DEF_DIV)) return DIV_W'(DEF_DIV);
        return r;
    endfunction

    assign apply      = pend_q && drained;
    assign tick       = (cnt_q == div_q - 1'b1);
    assign div_active = div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q      <= DIV_W'(DEF_DIV);
            pend_div_q <= DIV_W'(DEF_DIV);
            pend_q     <= 1'b0;
            cnt_q      <= '0;
        end else begin
            if (div_load) begin
                pend_q     <= 1'b1;
                pend_div_q <= clamp_div(div_req);
            end else if (apply) begin
                pend_q <= 1'b0;
            end
            if (apply) div_q <= pend_div_q;
            cnt_q <= (apply || tick) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hci_uart_tx.sv
module hci_uart_tx
    import hci_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        cfg_par,
    input  logic              cts_stop,
    input  logic              msg_active,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_pop,
    output logic              txd,
    output logic              busy,
    output logic              underflow
);

    tx_state_e   state;
    logic [10:0] sh;
    logic [3:0]  left;
    logic [3:0]  sub;

    assign fifo_pop = (state == TX_IDLE) && tick && !fifo_empty && !cts_stop;
    assign busy     = (state == TX_SHIFT);
    assign txd      = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TX_IDLE;
            sh        <= '1;
            left      <= '0;
            sub       <= '0;
            underflow <= 1'b0;
        end else begin
            underflow <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (fifo_pop) begin
                        sh    <= par_on(cfg_par) ? {1'b1, par_bit(fifo_data, cfg_par), fifo_data, 1'b0}
                                                 : {2'b11, fifo_data, 1'b0};
                        left  <= par_on(cfg_par) ? 4'd11 : 4'd10;
                        sub   <= '0;
                        state <= TX_SHIFT;
                    end
                end
                TX_SHIFT: begin
                    if (tick) begin
                        sub <= sub + 1'b1;
                        if (sub == 4'(OVS - 1)) begin
                            sh   <= {1'b1, sh[10:1]};
                            left <= left - 1'b1;
                            if (left == 4'd1) begin
                                state     <= TX_IDLE;
                                underflow <= msg_active && fifo_empty;
                            end
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hci_uart_rx.sv
module hci_uart_rx
    import hci_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        cfg_par,
    output logic              push,
    output logic [BYTE_W-1:0] data,
    output rx_evt_t           evt
);

    rx_state_e         state;
    logic [3:0]        sub;
    logic [2:0]        bitn;
    logic [1:0]        samp;
    logic [BYTE_W-1:0] shreg;
    logic              parv;
    logic [8:0]        lowcnt, hicnt;
    logic              armed;
    logic              vote, mid, last;
    logic [8:0]        ftick;

    assign vote  = maj3(samp[1], samp[0], rxd);
    assign mid   = tick && (sub == 4'(MID));
    assign last  = tick && (sub == 4'(OVS - 1));
    assign ftick = frame_ticks(cfg_par);
    assign data  = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            sub    <= '0;
            bitn   <= '0;
            samp   <= 2'b11;
            shreg  <= '0;
            parv   <= 1'b0;
            lowcnt <= '0;
            hicnt  <= '0;
            armed  <= 1'b0;
            push   <= 1'b0;
            evt    <= '0;
        end else begin
            push <= 1'b0;
            evt  <= '0;
            if (tick) samp <= {samp[0], rxd};

            // line held low beyond one frame
            if (rxd) begin
                lowcnt <= '0;
            end else if (tick && lowcnt != '1) begin
                lowcnt <= lowcnt + 1'b1;
                if (lowcnt == ftick) evt.brk <= 1'b1;
            end

            // line quiet for one frame after a completed frame
            if (!rxd) begin
                hicnt <= '0;
            end else if (tick && armed) begin
                if (hicnt == ftick - 1'b1) begin
                    evt.idle <= 1'b1;
                    armed    <= 1'b0;
                    hicnt    <= '0;
                end else begin
                    hicnt <= hicnt + 1'b1;
                end
            end

            case (state)
                RX_IDLE: begin
                    if (!rxd) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) sub <= sub + 1'b1;
                    if (mid && vote) begin
                        state <= RX_IDLE;
                    end else if (last) begin
                        state <= RX_DATA;
                        bitn  <= '0;
                    end
                end
                RX_DATA: begin
                    if (tick) sub <= sub + 1'b1;
                    if (mid) shreg <= {vote, shreg[BYTE_W-1:1]};
                    if (last) begin
                        bitn <= bitn + 1'b1;
                        if (bitn == 3'd7) state <= par_on(cfg_par) ? RX_PAR : RX_STOP;
                    end
                end
                RX_PAR: begin
                    if (tick) sub <= sub + 1'b1;
                    if (mid)  parv <= vote;
                    if (last) state <= RX_STOP;
                end
                RX_STOP: begin
                    if (tick) sub <= sub + 1'b1;
                    if (mid) begin
                        if (!vote) begin
                            evt.frame <= 1'b1;
                            state     <= RX_WAIT_HI;
                        end else begin
                            armed <= 1'b1;
                            hicnt <= '0;
                            state <= RX_IDLE;
                            if (par_on(cfg_par) && (parv != par_bit(shreg, cfg_par)))
                                evt.par <= 1'b1;
                            else
                                push <= 1'b1;
                        end
                    end
                end
                RX_WAIT_HI: begin
                    if (rxd) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hci_uart_xport.sv
module hci_uart_xport
    import hci_uart_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int DEF_DIV    = 26,
    parameter int MIN_DIV    = 1,
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uart_rx,
    output logic              uart_tx,
    input  logic              cts_stop,
    output logic              rts_stop,
    input  logic [7:0]        tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              tx_msg_active,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    input  logic              rx_pop,
    output logic [LVL_W-1:0]  rx_level,
    input  logic [1:0]        cfg_parity,
    input  logic [LVL_W-1:0]  cfg_rts_thresh,
    input  logic [LVL_W-1:0]  cfg_rts_hyst,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_div_load,
    output logic [DIV_W-1:0]  div_active,
    output logic [5:0]        err_flags,
    input  logic [5:0]        err_clr
);

    // two-flop synchronisers for the asynchronous line inputs
    localparam int NSYNC = 2;
    logic [NSYNC-1:0] sync_in, sync_rst, sync_out;
    assign sync_in  = {cts_stop, uart_rx};
    assign sync_rst = 2'b01;

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        logic [1:0] ff;
        always_ff @(posedge clk) begin
            if (rst) ff <= {2{sync_rst[g]}};
            else     ff <= {ff[0], sync_in[g]};
        end
        assign sync_out[g] = ff[1];
    end

    logic rx_s, cts_s;
    assign rx_s  = sync_out[0];
    assign cts_s = sync_out[1];

    logic              tick;
    logic              tx_empty, tx_full, tx_pop, tx_busy, tx_undf;
    logic [BYTE_W-1:0] tx_head;
    logic [LVL_W-1:0]  tx_level;
    logic              rx_push, rx_full, rx_empty;
    logic [BYTE_W-1:0] rx_byte;
    rx_evt_t           rx_evt;

    hci_baud_ctl #(
        .DIV_W  (DIV_W),
        .DEF_DIV(DEF_DIV),
        .MIN_DIV(MIN_DIV)
    ) u_baud (
        .clk       (clk),
        .rst       (rst),
        .div_req   (cfg_div),
        .div_load  (cfg_div_load),
        .drained   (tx_empty && !tx_busy),
        .tick      (tick),
        .div_active(div_active)
    );

    hci_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk  (clk),
        .rst  (rst),
        .push (tx_valid),
        .din  (tx_data),
        .pop  (tx_pop),
        .dout (tx_head),
        .empty(tx_empty),
        .full (tx_full),
        .level(tx_level)
    );

    hci_uart_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cfg_par   (cfg_parity),
        .cts_stop  (cts_s),
        .msg_active(tx_msg_active),
        .fifo_empty(tx_empty),
        .fifo_data (tx_head),
        .fifo_pop  (tx_pop),
        .txd       (uart_tx),
        .busy      (tx_busy),
        .underflow (tx_undf)
    );

    hci_uart_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rxd    (rx_s),
        .cfg_par(cfg_parity),
        .push   (rx_push),
        .data   (rx_byte),
        .evt    (rx_evt)
    );

    hci_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk  (clk),
        .rst  (rst),
        .push (rx_push),
        .din  (rx_byte),
        .pop  (rx_pop),
        .dout (rx_data),
        .empty(rx_empty),
        .full (rx_full),
        .level(rx_level)
    );

    assign tx_ready = !tx_full;
    assign rx_valid = !rx_empty;

    // stop request toward the host, with release hysteresis
    logic             rts_q;
    logic [LVL_W:0]   rel_sum;
    assign rel_sum  = {1'b0, rx_level} + {1'b0, cfg_rts_hyst};
    assign rts_stop = rts_q;

    always_ff @(posedge clk) begin
        if (rst)                                rts_q <= 1'b0;
        else if (rx_level > cfg_rts_thresh)     rts_q <= 1'b1;
        else if (rel_sum < {1'b0, cfg_rts_thresh}) rts_q <= 1'b0;
    end

    // sticky error flags, write-one-to-clear, set wins
    logic [ERR_W-1:0] err_q, err_set;
    always_comb begin
        err_set            = '0;
        err_set[ERR_BREAK] = rx_evt.brk;
        err_set[ERR_IDLE]  = rx_evt.idle;
        err_set[ERR_FRAME] = rx_evt.frame;
        err_set[ERR_OVFL]  = rx_push && rx_full;
        err_set[ERR_PAR]   = rx_evt.par;
        err_set[ERR_UNDF]  = tx_undf;
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= (err_q & ~err_clr) | err_set;
    end
    assign err_flags = err_q;

endmodule

// File: rtl/hci_uart_xport_chk.sv
module hci_uart_xport_chk #(
    parameter int LVL_W = 5,
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             uart_tx,
    input logic             rts_stop,
    input logic [5:0]       err_flags,
    input logic [5:0]       err_clr,
    input logic [DIV_W-1:0] div_active,
    input logic             tx_busy,
    input logic             tx_empty,
    input logic             cts_s,
    input logic             rx_push,
    input logic             rx_full,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] thr,
    input logic [LVL_W-1:0] hyst
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (uart_tx && !rts_stop && err_flags == 6'd0));

    p_line_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> uart_tx);

    p_no_start_on_stop_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(!cts_s));

    p_rts_raise_r7: assert property (@(posedge clk) disable iff (rst)
        (rx_level > thr) |=> rts_stop);

    p_rts_release_r7: assert property (@(posedge clk) disable iff (rst)
        (({1'b0, rx_level} + {1'b0, hyst}) < {1'b0, thr}) |=> !rts_stop);

    p_overflow_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full) |=> err_flags[3]);

    p_div_waits_drain_r13: assert property (@(posedge clk) disable iff (rst)
        (div_active != $past(div_active)) |-> $past(tx_empty && !tx_busy));

    p_flags_sticky_r14: assert property (@(posedge clk) disable iff (rst)
        ((~$past(err_clr) & $past(err_flags) & ~err_flags) == 6'd0));

endmodule

bind hci_uart_xport hci_uart_xport_chk #(.LVL_W(LVL_W), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .uart_tx   (uart_tx),
    .rts_stop  (rts_stop),
    .err_flags (err_flags),
    .err_clr   (err_clr),
    .div_active(div_active),
    .tx_busy   (tx_busy),
    .tx_empty  (tx_empty),
    .cts_s     (cts_s),
    .rx_push   (rx_push),
    .rx_full   (rx_full),
    .rx_level  (rx_level),
    .thr       (cfg_rts_thresh),
    .hyst      (cfg_rts_hyst)
);

// File: tb/sim_hci_uart_xport.sv
module sim_hci_uart_xport;

    localparam int DIV_W = 16;
    localparam int DDIV  = 8;
    localparam int DEPTH = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic             uart_rx = 1'b1, uart_tx, cts_stop = 1'b0, rts_stop;
    logic [7:0]       tx_data = '0, rx_data;
    logic             tx_valid = 1'b0, tx_ready, tx_msg_active = 1'b0;
    logic             rx_valid, rx_pop = 1'b0;
    logic [LW-1:0]    rx_level;
    logic [1:0]       cfg_parity = 2'd0;
    logic [LW-1:0]    cfg_rts_thresh = LW'(7), cfg_rts_hyst = LW'(2);
    logic [DIV_W-1:0] cfg_div = DIV_W'(DDIV), div_active;
    logic             cfg_div_load = 1'b0;
    logic [5:0]       err_flags, err_clr = '0;

    int checks = 0;
    int errors = 0;

    hci_uart_xport #(
        .DIV_W(DIV_W), .DEF_DIV(DDIV), .MIN_DIV(2), .FIFO_DEPTH(DEPTH)
    ) u0 (
        .clk(clk), .rst(rst), .uart_rx(uart_rx), .uart_tx(uart_tx),
        .cts_stop(cts_stop), .rts_stop(rts_stop),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_msg_active(tx_msg_active),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_pop(rx_pop), .rx_level(rx_level),
        .cfg_parity(cfg_parity), .cfg_rts_thresh(cfg_rts_thresh), .cfg_rts_hyst(cfg_rts_hyst),
        .cfg_div(cfg_div), .cfg_div_load(cfg_div_load), .div_active(div_active),
        .err_flags(err_flags), .err_clr(err_clr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int mode);
        return (^d) ^ (mode == 2);
    endfunction

    task automatic send_rx(input logic [7:0] d, input int div, input int mode,
                           input bit bad_par, input bit bad_stop);
        @(negedge clk) uart_rx = 1'b0;
        repeat (16 * div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            uart_rx = d[i];
            repeat (16 * div) @(negedge clk);
        end
        if (mode == 1 || mode == 2) begin
            uart_rx = exp_par(d, mode) ^ bad_par;
            repeat (16 * div) @(negedge clk);
        end
        uart_rx = !bad_stop;
        repeat (16 * div) @(negedge clk);
        uart_rx = 1'b1;
    endtask

    task automatic recv_tx(input int div, input int mode, output logic [7:0] d,
                           output logic p, output logic stp);
        p = 1'b0;
        while (uart_tx) @(negedge clk);
        repeat (8 * div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (16 * div) @(negedge clk);
            d[i] = uart_tx;
        end
        if (mode == 1 || mode == 2) begin
            repeat (16 * div) @(negedge clk);
            p = uart_tx;
        end
        repeat (16 * div) @(negedge clk);
        stp = uart_tx;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk) tx_data = b; tx_valid = 1'b1;
        @(negedge clk) tx_valid = 1'b0;
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        @(negedge clk);
        chk({tag, " valid"}, int'(rx_valid), 1);
        chk({tag, " data"}, int'(rx_data), int'(exp));
        rx_pop = 1'b1;
        @(negedge clk) rx_pop = 1'b0;
    endtask

    task automatic clr_flags();
        @(negedge clk) err_clr = 6'h3F;
        @(negedge clk) err_clr = 6'h00;
    endtask

    task automatic count_low(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!uart_tx) n++;
        end
    endtask

    function automatic int ref_clamp(input int r);
        if (r < 2) return 2;
        if (r > DDIV) return DDIV;
        return r;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, q [9];
        logic p, s;
        int n;
        void'($urandom(32'h1d5e));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 uart_tx", int'(uart_tx), 1);
        chk("R1 rts_stop", int'(rts_stop), 0);
        chk("R1 err_flags", int'(err_flags), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 div_active", int'(div_active), DDIV);
        chk("R1 tx_ready", int'(tx_ready), 1);

        // R2 start bit width then random bytes
        push_tx(8'hFF);
        while (uart_tx) @(negedge clk);
        n = 0;
        while (!uart_tx) begin n++; @(negedge clk); end
        chk("R2 start bit cycles", n, 16 * DDIV);
        repeat (10 * 16 * DDIV) @(negedge clk);
        for (int k = 0; k < 4; k++) q[k] = 8'($urandom);
        for (int k = 0; k < 4; k++) push_tx(q[k]);
        for (int k = 0; k < 4; k++) begin
            recv_tx(DDIV, 0, d, p, s);
            chk("R2 tx byte", int'(d), int'(q[k]));
            chk("R2 stop bit", int'(s), 1);
        end
        repeat (64) @(negedge clk);
        chk("R12 no underflow when no message", int'(err_flags[5]), 0);

        // R3 random receive
        for (int k = 0; k < 5; k++) q[k] = 8'($urandom);
        for (int k = 0; k < 5; k++) send_rx(q[k], DDIV, 0, 0, 0);
        for (int k = 0; k < 5; k++) pop_chk("R3 rx byte", q[k]);

        // R4 parity
        cfg_parity = 2'd1;
        push_tx(8'h07);
        recv_tx(DDIV, 1, d, p, s);
        chk("R4 even tx data", int'(d), 8'h07);
        chk("R4 even tx parity", int'(p), 1);
        send_rx(8'h07, DDIV, 1, 0, 0);
        pop_chk("R4 even rx good", 8'h07);
        clr_flags();
        send_rx(8'h35, DDIV, 1, 1, 0);
        repeat (8) @(negedge clk);
        chk("R4 parity flag", int'(err_flags[4]), 1);
        chk("R4 bad byte dropped", int'(rx_valid), 0);
        cfg_parity = 2'd2;
        push_tx(8'h07);
        recv_tx(DDIV, 2, d, p, s);
        chk("R4 odd tx parity", int'(p), 0);
        send_rx(8'h35, DDIV, 2, 0, 0);
        pop_chk("R4 odd rx good", 8'h35);
        cfg_parity = 2'd0;

        // R5 glitch on the receive line
        clr_flags();
        @(negedge clk) uart_rx = 1'b0;
        repeat (3 * DDIV) @(negedge clk);
        uart_rx = 1'b1;
        repeat (2 * 160 * DDIV) @(negedge clk);
        chk("R5 glitch no byte", int'(rx_valid), 0);
        chk("R5 glitch no framing", int'(err_flags[2]), 0);

        // R6 stop input while idle
        cts_stop = 1'b1;
        push_tx(8'hA5);
        count_low(2 * 160 * DDIV, n);
        chk("R6 held while stop high", n, 0);
        cts_stop = 1'b0;
        recv_tx(DDIV, 0, d, p, s);
        chk("R6 byte after release", int'(d), 8'hA5);

        // R6 stop input rising mid-frame
        push_tx(8'h3C);
        push_tx(8'hC3);
        fork
            recv_tx(DDIV, 0, d, p, s);
            begin
                wait (uart_tx == 1'b0);
                repeat (3 * 16 * DDIV) @(negedge clk);
                cts_stop = 1'b1;
            end
        join
        chk("R6 frame in flight completes", int'(d), 8'h3C);
        chk("R6 frame in flight stop", int'(s), 1);
        count_low(3 * 160 * DDIV, n);
        chk("R6 next byte held", n, 0);
        cts_stop = 1'b0;
        recv_tx(DDIV, 0, d, p, s);
        chk("R6 queued byte after release", int'(d), 8'hC3);

        // R7 stop request with hysteresis
        cfg_rts_thresh = LW'(3);
        cfg_rts_hyst   = LW'(1);
        for (int k = 0; k < 4; k++) q[k] = 8'(8'h40 + k);
        for (int k = 0; k < 3; k++) send_rx(q[k], DDIV, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R7 fill 3 not above", int'(rts_stop), 0);
        send_rx(q[3], DDIV, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R7 fill 4 raises", int'(rts_stop), 1);
        pop_chk("R7 pop", q[0]);
        repeat (2) @(negedge clk);
        chk("R7 fill 3 holds", int'(rts_stop), 1);
        pop_chk("R7 pop", q[1]);
        repeat (2) @(negedge clk);
        chk("R7 fill 2 holds", int'(rts_stop), 1);
        pop_chk("R7 pop", q[2]);
        repeat (2) @(negedge clk);
        chk("R7 fill 1 releases", int'(rts_stop), 0);
        pop_chk("R7 pop", q[3]);
        cfg_rts_thresh = LW'(7);
        cfg_rts_hyst   = LW'(2);

        // R8 overflow and R14 sticky clear
        clr_flags();
        for (int k = 0; k < 9; k++) q[k] = 8'($urandom);
        for (int k = 0; k < 9; k++) send_rx(q[k], DDIV, 0, 0, 0);
        repeat (4) @(negedge clk);
        chk("R8 overflow flag", int'(err_flags[3]), 1);
        chk("R8 level full", int'(rx_level), DEPTH);
        for (int k = 0; k < 8; k++) pop_chk("R8 kept contents", q[k]);
        chk("R8 ninth byte lost", int'(rx_valid), 0);
        repeat (100) @(negedge clk);
        chk("R14 flag stays set", int'(err_flags[3]), 1);
        @(negedge clk) err_clr = 6'h08;
        @(negedge clk) err_clr = 6'h00;
        chk("R14 flag cleared", int'(err_flags[3]), 0);

        // R9 framing
        clr_flags();
        send_rx(8'h5A, DDIV, 0, 0, 1);
        repeat (32) @(negedge clk);
        chk("R9 framing flag", int'(err_flags[2]), 1);
        chk("R9 no break on short low", int'(err_flags[0]), 0);
        chk("R9 byte dropped", int'(rx_valid), 0);

        // R10 break
        clr_flags();
        @(negedge clk) uart_rx = 1'b0;
        repeat (12 * 16 * DDIV) @(negedge clk);
        chk("R10 break flag", int'(err_flags[0]), 1);
        uart_rx = 1'b1;
        repeat (2 * 16 * DDIV) @(negedge clk);
        chk("R10 no byte from break", int'(rx_valid), 0);

        // R11 idle after frame
        clr_flags();
        send_rx(8'h66, DDIV, 0, 0, 0);
        chk("R11 not idle yet", int'(err_flags[1]), 0);
        repeat (11 * 16 * DDIV) @(negedge clk);
        chk("R11 idle flag", int'(err_flags[1]), 1);
        pop_chk("R11 byte", 8'h66);

        // R12 underflow
        clr_flags();
        tx_msg_active = 1'b1;
        push_tx(8'h81);
        recv_tx(DDIV, 0, d, p, s);
        repeat (16 * DDIV) @(negedge clk);
        chk("R12 underflow flag", int'(err_flags[5]), 1);
        tx_msg_active = 1'b0;

        // R13 deferred divisor change
        for (int k = 0; k < 3; k++) q[k] = 8'($urandom);
        for (int k = 0; k < 3; k++) push_tx(q[k]);
        @(negedge clk) cfg_div = DIV_W'(4); cfg_div_load = 1'b1;
        @(negedge clk) cfg_div_load = 1'b0;
        chk("R13 old divisor held", int'(div_active), DDIV);
        for (int k = 0; k < 3; k++) begin
            recv_tx(DDIV, 0, d, p, s);
            chk("R13 byte at old rate", int'(d), int'(q[k]));
        end
        chk("R13 held during last frame", int'(div_active), DDIV);
        repeat (16 * DDIV) @(negedge clk);
        chk("R13 new divisor applied", int'(div_active), 4);
        push_tx(8'h9C);
        recv_tx(4, 0, d, p, s);
        chk("R13 byte at new rate", int'(d), 8'h9C);
        send_rx(8'h27, 4, 0, 0, 0);
        pop_chk("R13 rx at new rate", 8'h27);
        repeat (16 * 4) @(negedge clk);
        @(negedge clk) cfg_div = DIV_W'(1); cfg_div_load = 1'b1;
        @(negedge clk) cfg_div_load = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 clamp low", int'(div_active), ref_clamp(1));
        @(negedge clk) cfg_div = DIV_W'(100); cfg_div_load = 1'b1;
        @(negedge clk) cfg_div_load = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 clamp high", int'(div_active), ref_clamp(100));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule